// File: doc/BRIEF.md
# Indirect Register Bridge

This block lets a host reach a bank of wide internal registers through six narrow direct registers: an address register, four 16-bit data registers and a status register. The host stages write data in the data registers, then writes the address register; that single write launches the transaction. Bit 7 of the address picks the direction. A write stores all four data halfwords into the addressed internal location. A read places one addressed halfword into data register 0. The low address bits pick the halfword, so a 32-bit quantity comes back as two reads whose addresses differ only in bit 0.

Each transaction occupies the internal side for a fixed number of clock cycles, set by a parameter. During that time a busy flag in the status register is set, and the host polls it before it starts the next access. An address write that arrives while busy is dropped and latches a sticky error flag. The status register also carries two active-low reset controls, for the global logic and for the codec, which leave the block as pins.

Top module: `ireg_bridge`

## Requirements
- R1: After reset every direct register reads as zero: address, data 0 to 3 and status. Both reset pins are low (asserted).
- R2: A write to the address register (select 0) while idle starts a transaction. Status bit 0 (busy) then reads 1 for exactly LATENCY cycles and afterwards reads 0.
- R3: When address bit 7 is 0, the transaction is a write. At completion, internal location addr[6:2] holds data register k in halfword k, for k = 0 to 3. Address bits 1:0 are ignored on a write.
- R4: When address bit 7 is 1, the transaction is a read. At completion, data register 0 holds halfword addr[1:0] of location addr[6:2], so that addresses differing only in bit 0 return the low and the high half of a 32-bit value.
- R5: The write data is captured when the transaction launches. A data register written while busy does not change what is stored.
- R6: An address write made while busy is ignored: the address readback and the running transaction are unchanged. It also sets status bit 1 (error).
- R7: The error bit is sticky. Writing status with bit 1 set clears it. A status write with bit 1 clear leaves it set.
- R8: Status bit 2 drives the global reset pin and status bit 3 drives the codec reset pin, both active low. Writing 0 to a bit asserts its reset, writing 1 releases it, and the two bits are independent.
- R9: Only bits 15:0 of a write to a data register are kept. Bits 31:16 of a data register read back as zero.
- R10: The select map is: 0 for address, 1 to 4 for data 0 to 3, and 5 for status. Selects 6 and 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 3 | Direct register select |
| host_we | input | 1 | Write strobe for the selected register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected register (combinational) |
| glob_rst_n | output | 1 | Global reset control, active low |
| codec_rst_n | output | 1 | Codec reset control, active low |

## Verification
The hardest situation to reach is a host access that lands inside the busy window, because a well-behaved host only writes after the busy flag clears. The stimulus creates it on purpose: it launches a transaction and, in the very next cycle, writes a data register or the address register again. It then checks that the stored payload, the address readback and the completion are untouched, and that the error flag latched. A table of write and read transactions then covers both directions, every halfword position, the top location, and a write whose address has low bits set.

// File: rtl/ireg_pkg.sv
package ireg_pkg;

  localparam int SEL_W  = 3;
  localparam int HALF_W = 16;
  localparam int NDATA  = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_ADDR = 3'd0,
    SEL_D0   = 3'd1,
    SEL_D1   = 3'd2,
    SEL_D2   = 3'd3,
    SEL_D3   = 3'd4,
    SEL_STAT = 3'd5
  } sel_e;

  // status register bit positions
  localparam int ST_BUSY = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_GRST = 2;
  localparam int ST_CRST = 3;

endpackage

// File: rtl/ireg_seq.sv
module ireg_seq #(
  parameter int ADDR_W  = 8,
  parameter int LATENCY = 4,
  parameter int NH      = 4,
  parameter int HALF_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         launch_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [NH-1:0][HALF_W-1:0]    payload_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         clash_o,
  output logic [ADDR_W-1:0]            addr_o,
  output logic [NH-1:0][HALF_W-1:0]    payload_o
);

  localparam int CNT_W = $clog2(LATENCY + 1);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e                      st_q, st_d;
  logic [CNT_W-1:0]            cnt_q, cnt_d;
  logic                        cap_en;
  logic [ADDR_W-1:0]           addr_q;
  logic [NH-1:0][HALF_W-1:0]   pay_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cap_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (launch_i) begin
          st_d   = ST_RUN;
          cnt_d  = CNT_W'(LATENCY);
          cap_en = 1'b1;
        end
      end
      default: begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      pay_q  <= '0;
    end else if (cap_en) begin
      addr_q <= addr_i;
      pay_q  <= payload_i;
    end
  end

  assign busy_o    = (st_q == ST_RUN);
  assign done_o    = busy_o && (cnt_q == CNT_W'(1));
  assign clash_o   = launch_i && busy_o;
  assign addr_o    = addr_q;
  assign payload_o = pay_q;

endmodule

// File: rtl/ireg_bank.sv
module ireg_bank #(
  parameter int IDX_W  = 5,
  parameter int HSEL_W = 2,
  parameter int HALF_W = 16
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [(1<<HSEL_W)-1:0][HALF_W-1:0] wr_data,
  input  logic [IDX_W-1:0]              rd_idx,
  input  logic [HSEL_W-1:0]             rd_half,
  output logic [HALF_W-1:0]             rd_data
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int NH    = 1 << HSEL_W;

  logic [NH-1:0][HALF_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx][rd_half];

endmodule

// File: rtl/ireg_hostregs.sv
module ireg_hostregs
  import ireg_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SEL_W-1:0]              sel,
  input  logic                          we,
  input  logic [HOST_W-1:0]             wdata,
  input  logic                          busy_i,
  input  logic                          clash_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          load_i,
  input  logic [HALF_W-1:0]             load_data,
  output logic [NDATA-1:0][HALF_W-1:0]  data_o,
  output logic                          err_o,
  output logic                          grst_n_o,
  output logic                          crst_n_o,
  output logic [HOST_W-1:0]             rdata
);

  logic [NDATA-1:0][HALF_W-1:0] d_q, d_n;
  logic err_q, err_n, grst_q, grst_n, crst_q, crst_n;
  logic stat_we;
  logic unused_hi;

  assign stat_we   = we && (sel == SEL_STAT);
  assign unused_hi = ^wdata[HOST_W-1:HALF_W];

  always_comb begin
    d_n = d_q;
    for (int k = 0; k < NDATA; k++) begin
      if (we && (sel == SEL_W'(int'(SEL_D0) + k))) d_n[k] = wdata[HALF_W-1:0];
    end
    if (load_i) d_n[0] = load_data;
  end

  always_comb begin
    err_n  = err_q;
    grst_n = grst_q;
    crst_n = crst_q;
    if (clash_i) err_n = 1'b1;
    else if (stat_we && wdata[ST_ERR]) err_n = 1'b0;
    if (stat_we) begin
      grst_n = wdata[ST_GRST];
      crst_n = wdata[ST_CRST];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q    <= '0;
      err_q  <= 1'b0;
      grst_q <= 1'b0;
      crst_q <= 1'b0;
    end else begin
      d_q    <= d_n;
      err_q  <= err_n;
      grst_q <= grst_n;
      crst_q <= crst_n;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_ADDR: rdata = HOST_W'(addr_i);
      SEL_D0:   rdata = HOST_W'(d_q[0]);
      SEL_D1:   rdata = HOST_W'(d_q[1]);
      SEL_D2:   rdata = HOST_W'(d_q[2]);
      SEL_D3:   rdata = HOST_W'(d_q[3]);
      SEL_STAT: begin
        rdata[ST_BUSY] = busy_i;
        rdata[ST_ERR]  = err_q;
        rdata[ST_GRST] = grst_q;
        rdata[ST_CRST] = crst_q;
      end
      default:  rdata = '0;
    endcase
  end

  assign data_o   = d_q;
  assign err_o    = err_q;
  assign grst_n_o = grst_q;
  assign crst_n_o = crst_q;

endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge
  import ireg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int HOST_W  = 32,
  parameter int LATENCY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        host_sel,
  input  logic              host_we,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              glob_rst_n,
  output logic              codec_rst_n
);

  localparam int RD_BIT = ADDR_W - 1;
  localparam int HSEL_W = $clog2(NDATA);
  localparam int IDX_W  = ADDR_W - 1 - HSEL_W;

  logic [1:0]                   rst_sync_q;
  logic                         rst_int_n;
  logic                         launch_w, busy_w, done_w, clash_w, err_w;
  logic [ADDR_W-1:0]            op_addr;
  logic [NDATA-1:0][HALF_W-1:0] data_w, pay_w;
  logic [HALF_W-1:0]            rd_half_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign launch_w = host_we && (host_sel == SEL_ADDR);

  ireg_seq #(
    .ADDR_W(ADDR_W), .LATENCY(LATENCY), .NH(NDATA), .HALF_W(HALF_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .launch_i  (launch_w),
    .addr_i    (host_wdata[ADDR_W-1:0]),
    .payload_i (data_w),
    .busy_o    (busy_w),
    .done_o    (done_w),
    .clash_o   (clash_w),
    .addr_o    (op_addr),
    .payload_o (pay_w)
  );

  ireg_bank #(
    .IDX_W(IDX_W), .HSEL_W(HSEL_W), .HALF_W(HALF_W)
  ) u_bank (
    .clk     (clk),
    .wr_en   (done_w && !op_addr[RD_BIT]),
    .wr_idx  (op_addr[RD_BIT-1:HSEL_W]),
    .wr_data (pay_w),
    .rd_idx  (op_addr[RD_BIT-1:HSEL_W]),
    .rd_half (op_addr[HSEL_W-1:0]),
    .rd_data (rd_half_data)
  );

  ireg_hostregs #(
    .HOST_W(HOST_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sel       (host_sel),
    .we        (host_we),
    .wdata     (host_wdata),
    .busy_i    (busy_w),
    .clash_i   (clash_w),
    .addr_i    (op_addr),
    .load_i    (done_w && op_addr[RD_BIT]),
    .load_data (rd_half_data),
    .data_o    (data_w),
    .err_o     (err_w),
    .grst_n_o  (glob_rst_n),
    .crst_n_o  (codec_rst_n),
    .rdata     (host_rdata)
  );

endmodule

// File: rtl/ireg_bridge_chk.sv
module ireg_bridge_chk #(
  parameter int LATENCY = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] host_sel,
  input logic       host_we,
  input logic [2:0] stat_bits,
  input logic       busy,
  input logic       err,
  input logic       glob_rst_n,
  input logic       codec_rst_n
);

  logic [31:0] run_q;
  logic        addr_wr, stat_wr;

  assign addr_wr = host_we && (host_sel == 3'd0);
  assign stat_wr = host_we && (host_sel == 3'd5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == 32'(LATENCY))); // R2

  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && !busy) |=> busy); // R2

  AST_CLASH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && busy) |=> err); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(stat_wr && stat_bits[0])) |=> err); // R7

  AST_RST_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((glob_rst_n == $past(stat_bits[1])) &&
                 (codec_rst_n == $past(stat_bits[2])))); // R8

endmodule

bind ireg_bridge ireg_bridge_chk #(.LATENCY(LATENCY)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .host_sel    (host_sel),
  .host_we     (host_we),
  .stat_bits   (host_wdata[3:1]),
  .busy        (busy_w),
  .err         (err_w),
  .glob_rst_n  (glob_rst_n),
  .codec_rst_n (codec_rst_n)
);

// File: tb/tb_ireg_bridge.sv
module tb_ireg_bridge;

  localparam int LAT  = 4;
  localparam int NVEC = 12;

  logic        clk;
  logic        rst_n;
  logic [2:0]  host_sel;
  logic        host_we;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        glob_rst_n;
  logic        codec_rst_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ireg_bridge #(.LATENCY(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .glob_rst_n(glob_rst_n), .codec_rst_n(codec_rst_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {read, address, data3..data0 payload, expected data0 after a read}
  localparam logic [88:0] VEC [NVEC] = '{
    {1'b0, 8'h0C, 64'h1111_2222_3333_4444, 16'h0000},
    {1'b1, 8'h8C, 64'h0,                   16'h4444},
    {1'b1, 8'h8D, 64'h0,                   16'h3333},
    {1'b1, 8'h8E, 64'h0,                   16'h2222},
    {1'b1, 8'h8F, 64'h0,                   16'h1111},
    {1'b0, 8'h7C, 64'hFEDC_BA98_7654_3210, 16'h0000},
    {1'b1, 8'hFD, 64'h0,                   16'h7654},
    {1'b1, 8'hFC, 64'h0,                   16'h3210},
    {1'b0, 8'h05, 64'h0000_0000_CAFE_F00D, 16'h0000},
    {1'b1, 8'h84, 64'h0,                   16'hF00D},
    {1'b1, 8'h85, 64'h0,                   16'hCAFE},
    {1'b1, 8'h8F, 64'h0,                   16'h1111}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] s, input logic [31:0] d);
    host_sel = s; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input logic [2:0] s, output logic [31:0] d);
    host_sel = s;
    #1;
    d = host_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] st;
    cyc = 0;
    hread(3'd5, st);
    while (st[0] && cyc < 1000) begin
      cyc++;
      @(negedge clk);
      hread(3'd5, st);
    end
  endtask

  task automatic load_data(input logic [63:0] w);
    for (int k = 0; k < 4; k++) hwrite(3'(k + 1), {16'h0, w[16*k +: 16]});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int cyc;
    host_sel = 3'd0; host_we = 1'b0; host_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 6; s++) begin
      hread(3'(s), v);
      check("R1 register reads zero", v, 32'h0);
    end
    check("R1 reset pins asserted", {30'h0, glob_rst_n, codec_rst_n}, 32'h0);

    hwrite(3'd5, 32'h0000_000C);

    // table walk: R2 busy length, R3 write storage, R4 read half select
    for (int i = 0; i < NVEC; i++) begin
      if (!VEC[i][88]) load_data(VEC[i][79:16]);
      hwrite(3'd0, {24'h0, VEC[i][87:80]});
      wait_idle(cyc);
      check("R2 busy cycles", cyc, LAT);
      if (VEC[i][88]) begin
        hread(3'd1, v);
        check("R3 R4 read data", v, {16'h0, VEC[i][15:0]});
      end
    end

    // R5 data written while busy does not alter the stored payload
    load_data(64'h0D0D_0C0C_0B0B_0A0A);
    hwrite(3'd0, 32'h08);
    hwrite(3'd1, 32'hFFFF);
    hwrite(3'd2, 32'hEEEE);
    wait_idle(cyc);
    hwrite(3'd0, 32'h88);
    wait_idle(cyc);
    hread(3'd1, v);
    check("R5 half0 from launch", v, 32'h0A0A);
    hwrite(3'd0, 32'h89);
    wait_idle(cyc);
    hread(3'd1, v);
    check("R5 half1 from launch", v, 32'h0B0B);

    // R6 address write during busy is dropped and flags error
    load_data(64'h4444_3333_2222_1234);
    hwrite(3'd0, 32'h10);
    hwrite(3'd0, 32'h94);
    hread(3'd0, v);
    check("R6 address unchanged", v, 32'h10);
    hread(3'd5, v);
    check("R6 error set", {31'h0, v[1]}, 32'h1);
    wait_idle(cyc);
    hwrite(3'd0, 32'h90);
    wait_idle(cyc);
    hread(3'd1, v);
    check("R6 first write completed", v, 32'h1234);

    // R7 sticky error, write-one clear
    hwrite(3'd5, 32'h0000_000C);
    hread(3'd5, v);
    check("R7 error kept", v, 32'h0000_000E);
    hwrite(3'd5, 32'h0000_000E);
    hread(3'd5, v);
    check("R7 error cleared", v, 32'h0000_000C);

    // R8 independent reset pins
    hwrite(3'd5, 32'h4);
    check("R8 global released only", {30'h0, glob_rst_n, codec_rst_n}, 32'h2);
    hwrite(3'd5, 32'h8);
    check("R8 codec released only", {30'h0, glob_rst_n, codec_rst_n}, 32'h1);
    hwrite(3'd5, 32'h0);
    check("R8 both asserted", {30'h0, glob_rst_n, codec_rst_n}, 32'h0);
    hwrite(3'd5, 32'hC);
    check("R8 both released", {30'h0, glob_rst_n, codec_rst_n}, 32'h3);

    // R9 upper bits of data registers dropped
    hwrite(3'd2, 32'hDEAD_BEEF);
    hread(3'd2, v);
    check("R9 data width", v, 32'h0000_BEEF);

    // R10 unused selects
    hread(3'd6, v);
    check("R10 select 6 reads zero", v, 32'h0);
    hwrite(3'd7, 32'hFFFF_FFFF);
    hwrite(3'd6, 32'hFFFF_FFFF);
    hread(3'd7, v);
    check("R10 select 7 reads zero", v, 32'h0);
    hread(3'd2, v);
    check("R10 data1 untouched", v, 32'h0000_BEEF);
    hread(3'd5, v);
    check("R10 status untouched", v, 32'h0000_000C);
    hread(3'd0, v);
    check("R10 address readback", v, 32'h90);

    finish_run();
  end

endmodule